// File: doc/BRIEF.md
# Way-Tag Queue for Write-Through Store Drain

This block is a small first-in first-out queue of cache way tags. In a write-through data cache, every store that hits goes into a write buffer on its way to the lower-level cache. The way tag of the line, which records the lower-level way that holds the copy, is read from the way-tag array in the same access. The tag only becomes available one cycle after the store enters the write buffer. This queue holds those tags in store order. When the write buffer sends its oldest store downstream, the matching tag leaves the queue in the same cycle and drives the way decoder. The decoder then enables a single way of the lower-level cache instead of all of them.

The caller raises `store_push` in the cycle its store enters the write buffer. It presents the way tag on `tag_in` in the following cycle. The queue delays the push request internally by one cycle so that the request and the tag line up. Pops come from `drain_req`, which the write-buffer drain drives. The queue gates pops with its own empty flag, so a drain request while the queue is empty has no effect. The push side and the pop side are independent and can both act in the same cycle. The depth is meant to equal the write-buffer depth. A push that arrives while the queue is full is dropped and sets a sticky overflow flag.

Top module: `waytag_fifo`

## Requirements
- R1: After a synchronous reset, `empty` is 1 and both `full` and `overflow` are 0.
- R2: A tag on `tag_in` in the cycle after `store_push` was sampled high is stored. In the next cycle `empty` is 0 and, if the queue held nothing before, the tag appears on `tag_out`.
- R3: Tags leave in the order they were stored. `tag_out` always shows the oldest stored tag, and each accepted `drain_req` advances to the next tag.
- R4: A `drain_req` while `empty` is 1 is ignored. No tag is lost, and the stored contents and flags are unchanged.
- R5: A push and an accepted pop in the same cycle leave the tag count unchanged and advance the head.
- R6: If a delayed push and a `drain_req` meet an empty queue in the same cycle, the pop is ignored. The pushed tag is readable on `tag_out` from the next cycle.
- R7: `full` is 1 exactly when DEPTH tags are held, `empty` is 1 exactly when none are held, and the two are never 1 together.
- R8: A delayed push that arrives while `full` is 1 is dropped, even if a pop occurs in the same cycle. It sets `overflow`, which stays 1 until reset.
- R9: While the queue is not empty and no `drain_req` is made, `tag_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| store_push | input | 1 | A store entered the write buffer this cycle |
| tag_in | input | TAG_W | Way tag of the store pushed in the previous cycle |
| drain_req | input | 1 | Write buffer sends its oldest store downstream this cycle |
| tag_out | output | TAG_W | Way tag of the oldest queued store, to the way decoder |
| empty | output | 1 | No tag held; doubles as the read enable |
| full | output | 1 | DEPTH tags held |
| overflow | output | 1 | Sticky: a push was dropped because the queue was full |

## Verification
The bench targets the points where the one-cycle push lag meets the pop side. The first is a drain on an empty queue with a push pending. A design that lets the pop through would underflow and return a stale tag. A design that forgets the lag would store the wrong cycle's `tag_in`, so every decoded way would be off by one store. The second case is the full boundary, where a push meets a simultaneous pop. A design that admits the push would overwrite the head or miscount, and the sticky flag is also checked there. Random mixed traffic then checks that the tag order and the flag values stay aligned with a reference queue.

// File: rtl/waytag_fifo_pkg.sv
package waytag_fifo_pkg;

  // Combined action of the two independent queue ports in one cycle.
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;

endpackage

// File: rtl/waytag_fifo_store.sv
module waytag_fifo_store #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [TAG_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [TAG_W-1:0] rdata
);

  // Storage array with no reset, so it maps onto distributed RAM.
  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous read, so the head is visible with no extra cycle.
  assign rdata = mem[raddr];

endmodule

// File: rtl/waytag_fifo_ptrs.sv
module waytag_fifo_ptrs
  import waytag_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          empty,
  output logic          full,
  output logic          overflow
);

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;
  fifo_op_e      op;

  // The top bit of each pointer is a wrap bit. It separates the full state
  // from the empty state when the address bits are equal.
  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);

  // The empty flag is the read enable and the full flag is the write enable.
  assign do_push = push_req && !full;
  assign do_pop  = pop_req && !empty;
  assign op      = fifo_op_e'({do_push, do_pop});

  assign wr_en   = do_push;
  assign wr_addr = wr_ptr[AW-1:0];
  assign rd_addr = rd_ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
    end else begin
      case (op)
        OP_PUSH: wr_ptr <= wr_ptr + 1'b1;
        OP_POP:  rd_ptr <= rd_ptr + 1'b1;
        OP_BOTH: begin
          wr_ptr <= wr_ptr + 1'b1;
          rd_ptr <= rd_ptr + 1'b1;
        end
        default: ;
      endcase
      if (push_req && full) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/waytag_fifo.sv
module waytag_fifo #(
  parameter int DEPTH = 8,               // equals write-buffer depth; power of two, >= 2
  parameter int WAYS  = 8,               // ways in the lower-level cache
  localparam int TAG_W = $clog2(WAYS),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             store_push,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             drain_req,
  output logic [TAG_W-1:0] tag_out,
  output logic             empty,
  output logic             full,
  output logic             overflow
);

  // The way tag leaves the way-tag array one cycle after the store enters
  // the write buffer, so the push request is delayed to line up with it.
  logic          push_q;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;

  always_ff @(posedge clk) begin
    if (rst) push_q <= 1'b0;
    else     push_q <= store_push;
  end

  waytag_fifo_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_q),
    .pop_req  (drain_req),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .empty    (empty),
    .full     (full),
    .overflow (overflow)
  );

  waytag_fifo_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) store_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (tag_in),
    .raddr (rd_addr),
    .rdata (tag_out)
  );

endmodule

// File: rtl/waytag_fifo_chk.sv
module waytag_fifo_chk #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             push_q,
  input logic             drain_req,
  input logic [TAG_W-1:0] tag_out,
  input logic             empty,
  input logic             full,
  input logic             overflow
);

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R2
  push_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (push_q && !full) |=> !empty);

  // R4
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && !push_q) |=> empty);

  // R8
  overflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    (push_q && full) |=> overflow);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!empty && !drain_req) |=> $stable(tag_out));

endmodule

bind waytag_fifo waytag_fifo_chk #(.TAG_W(TAG_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .push_q    (push_q),
  .drain_req (drain_req),
  .tag_out   (tag_out),
  .empty     (empty),
  .full      (full),
  .overflow  (overflow)
);

// File: tb/waytag_fifo_test.sv
`timescale 1ns/1ps
module waytag_fifo_test;

  localparam int DEPTH = 8;
  localparam int WAYS  = 8;
  localparam int TW    = $clog2(WAYS);

  logic          clk = 1'b0;
  logic          rst;
  logic          store_push, drain_req;
  logic [TW-1:0] tag_in, tag_out;
  logic          empty, full, overflow;

  always #2 clk = ~clk;

  waytag_fifo #(.DEPTH(DEPTH), .WAYS(WAYS)) uut (
    .clk(clk), .rst(rst), .store_push(store_push), .tag_in(tag_in),
    .drain_req(drain_req), .tag_out(tag_out), .empty(empty),
    .full(full), .overflow(overflow)
  );

  int            n_run = 0, n_fail = 0;
  bit            done = 0;
  logic [TW-1:0] mq[$];
  bit            m_pend = 0, m_ovf = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    chk(req, "empty", int'(empty), int'(mq.size() == 0));
    chk(req, "full", int'(full), int'(mq.size() == DEPTH));
    chk(req, "overflow", int'(overflow), int'(m_ovf));
    if (mq.size() > 0) chk(req, "tag_out", int'(tag_out), int'(mq[0]));
  endtask

  // Drive one cycle (inputs at negedge), update the reference queue, check.
  task automatic step(bit p, bit d, logic [TW-1:0] t, string req);
    bit full_now;
    store_push = p; drain_req = d; tag_in = t;
    full_now = (mq.size() == DEPTH);
    if (d && mq.size() > 0) void'(mq.pop_front());
    if (m_pend) begin
      if (full_now) m_ovf = 1;
      else mq.push_back(t);
    end
    m_pend = p;
    @(posedge clk);
    @(negedge clk);
    check_outputs(req);
  endtask

  task automatic do_reset();
    rst = 1'b1; store_push = 0; drain_req = 0; tag_in = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mq.delete(); m_pend = 0; m_ovf = 0;
    check_outputs("R1");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R4: drain on empty
    step(0, 1, '0, "R4");
    step(0, 1, '0, "R4");
    // R2: push, tag one cycle later
    step(1, 0, '0, "R2");
    step(0, 0, 3'd5, "R2");
    step(0, 1, '0, "R3");
    // R6: push and drain meeting an empty queue
    step(1, 0, '0, "R6");
    step(0, 1, 3'd6, "R6");
    step(0, 1, '0, "R6");
    // R3 ordering, R5 simultaneous
    step(1, 0, '0, "R3");
    for (int k = 1; k < 4; k++) step(1, 0, TW'(k), "R3");
    step(1, 1, 3'd4, "R5");
    step(0, 1, 3'd7, "R5");
    while (mq.size() > 0) step(0, 1, '0, "R3");
    step(0, 1, '0, "R4");
    // R7 fill to full, R8 overflow, R9 hold
    step(1, 0, '0, "R7");
    for (int i = 0; i < DEPTH; i++) step(1, 0, TW'(i + 2), "R7");
    step(0, 0, 3'd3, "R8");
    step(0, 0, '0, "R9");
    step(1, 0, '0, "R9");
    step(0, 1, 3'd1, "R8");
    step(0, 0, '0, "R8");
    do_reset();
    // Random mixed traffic
    for (int c = 0; c < 4000; c++)
      step($urandom_range(0, 99) < 48, $urandom_range(0, 99) < 50,
           TW'($urandom_range(0, WAYS - 1)), "R3");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule